// File: doc/BRIEF.md
# B8ZS-aware bipolar violation counter

This block takes a T1 receive stream as one positive-pulse and one negative-pulse indication per bit clock. It returns the stream to unipolar data, turning every valid B8ZS substitution back into eight zeros. It also keeps a wrapping count of the genuine bipolar coding violations.

Violations that belong to a legal substitution are removed before anything is counted. Only real coding errors move the counter.

An eight-stage delay line holds the most recent symbols. The oldest eight are compared against the substitution pattern, which is referenced to the polarity of the last mark that has already left the line. A match clears all eight stages at once. Each symbol is judged as it leaves the line, so it appears on the data output a fixed eight clocks after it was sampled.

Top module: `b8zs_bpv_counter`

## Requirements
- R1: A symbol sampled at clock edge n appears on `data_o` right after edge n+8. `data_o` is 1 for a mark (either pulse input high) and 0 for a space, unless the symbol was replaced by a substitution.
- R2: Marks of alternating polarity, with or without spaces between them, never change the count.
- R3: A single-polarity mark whose polarity equals that of the previous mark increments the count by one. It then becomes the reference polarity for the next mark.
- R4: A symbol with both pulse inputs high counts as one violation and is output as 1. It does not change the reference polarity.
- R5: If the last mark was positive, the eight symbols 0,0,0,+,-,0,-,+ are output as eight zeros and add nothing to the count. The reference polarity stays positive afterwards.
- R6: If the last mark was negative, the eight symbols 0,0,0,-,+,0,+,- are output as eight zeros and add nothing to the count. The reference polarity stays negative afterwards.
- R7: An eight-symbol group with the substitution shape but the wrong polarities is not replaced. Its marks pass through and each same-polarity repeat is counted.
- R8: The count is 8 bits wide and wraps from 255 to 0 on the next violation.
- R9: Reset clears the count, the output and the delay line, and forgets the reference polarity. The first single-polarity mark after reset is never counted.
- R10: Without any mark since reset, the substitution pattern is not recognized. Its marks pass through and are counted by R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one symbol per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pos_i | input | 1 | Positive pulse received in this bit |
| neg_i | input | 1 | Negative pulse received in this bit |
| data_o | output | 1 | Recovered unipolar data, 8 clocks behind the input |
| bpv_cnt_o | output | 8 | Wrapping count of violations outside substitutions |

## Verification
The embedded properties that look nine edges back assume the nine preceding edges were free of reset. They are gated by a small counter of reset-free cycles, so stimulus that is cut short by a reset never trips them.

The stimulus keeps the pulse inputs at zero while reset is asserted and between stimulus streams. Each vector therefore starts from a known polarity and a flushed delay line. Zeros are fed after every stream until every symbol has left the line.

// File: rtl/b8zs_bpv_counter.sv
module b8zs_bpv_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pos_i,
  input  logic             neg_i,
  output logic             data_o,
  output logic [CNT_W-1:0] bpv_cnt_o
);
  localparam int DLY = 8;
  localparam logic [DLY-1:0] SAME_POL = 8'b0001_0001;
  localparam logic [DLY-1:0] OPP_POL  = 8'b0000_1010;

  logic [DLY-1:0] dp, dn;
  logic           last_pos, seen;

  wire ep    = dp[DLY-1];
  wire en    = dn[DLY-1];
  wire both  = ep & en;
  wire mark  = ep | en;
  wire viol  = both | (mark & seen & (ep == last_pos));
  wire subst = seen &&
               (dp == (last_pos ? SAME_POL : OPP_POL)) &&
               (dn == (last_pos ? OPP_POL : SAME_POL));

  always_ff @(posedge clk) begin
    if (rst) begin
      dp        <= '0;
      dn        <= '0;
      last_pos  <= 1'b0;
      seen      <= 1'b0;
      data_o    <= 1'b0;
      bpv_cnt_o <= '0;
    end else begin
      dp        <= subst ? {{(DLY-1){1'b0}}, pos_i} : {dp[DLY-2:0], pos_i};
      dn        <= subst ? {{(DLY-1){1'b0}}, neg_i} : {dn[DLY-2:0], neg_i};
      data_o    <= mark;
      bpv_cnt_o <= bpv_cnt_o + CNT_W'(viol);
      if (mark && !both) begin
        last_pos <= ep;
        seen     <= 1'b1;
      end
    end
  end

  logic [3:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 4'd15) since_rst <= since_rst + 4'd1;
  end

  // R3, R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (bpv_cnt_o == $past(bpv_cnt_o)) || (bpv_cnt_o == $past(bpv_cnt_o) + CNT_W'(1)));

  // R9
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (bpv_cnt_o == '0) && !data_o);

  // R4
  both_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 4'd9 && $past(pos_i && neg_i, 9)) |-> bpv_cnt_o == $past(bpv_cnt_o) + CNT_W'(1));

  // R1
  data_src_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 4'd9 && data_o) |-> $past(pos_i || neg_i, 9));
endmodule

// File: tb/b8zs_bpv_counter_test.sv
module b8zs_bpv_counter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_pos = 1'b0;
  logic in_neg = 1'b0;
  logic data_o;
  logic [7:0] cnt;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  b8zs_bpv_counter uut (.clk(clk), .rst(rst), .pos_i(in_pos), .neg_i(in_neg),
                        .data_o(data_o), .bpv_cnt_o(cnt));

  localparam int NV = 7;
  localparam string STIM [NV] = '{"P0N0P0N0", "PPNN", "PBN", "P000PN0NPN",
                                  "N000NP0PNP", "P000NP0PN", "000PN0NP"};
  localparam string EXPD [NV] = '{"10101010", "1111", "111", "1000000001",
                                  "1000000001", "100011011", "00011011"};
  localparam int    EXPC [NV] = '{0, 2, 1, 0, 0, 1, 1};
  localparam string TAGS [NV] = '{"R1 R2", "R3", "R4", "R5", "R6", "R7", "R10"};

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_str(input string req, input string act, input string exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_pos = 1'b0; in_neg = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_stream(input string s, output string got);
    got = "";
    for (int i = 0; i < s.len() + 9; i++) begin
      @(negedge clk);
      if (i >= 9) got = {got, data_o ? "1" : "0"};
      if (i < s.len()) begin
        in_pos = (s[i] == "P") || (s[i] == "B");
        in_neg = (s[i] == "N") || (s[i] == "B");
      end else begin
        in_pos = 1'b0;
        in_neg = 1'b0;
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    string got, s, ones;
    do_reset();
    @(negedge clk);
    // R9: state right after reset
    check_int("R9 reset count", cnt, 0);
    check_int("R9 reset data", data_o, 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      run_stream(STIM[v], got);
      check_str({TAGS[v], " data"}, got, EXPD[v]);
      check_int({TAGS[v], " count"}, cnt, EXPC[v]);
    end

    // R8: 256 positive marks give 255 violations, one more wraps
    do_reset();
    s = ""; ones = "";
    for (int i = 0; i < 256; i++) begin
      s = {s, "P"};
      ones = {ones, "1"};
    end
    run_stream(s, got);
    check_str("R8 data", got, ones);
    check_int("R8 count at 255", cnt, 255);
    run_stream("P", got);
    check_int("R8 wrap to 0", cnt, 0);

    // R9: reset forgets polarity
    do_reset();
    run_stream("PP", got);
    check_int("R9 pre-reset count", cnt, 1);
    do_reset();
    @(negedge clk);
    check_int("R9 count cleared", cnt, 0);
    run_stream("P", got);
    check_int("R9 first mark not counted", cnt, 0);
    check_str("R9 first mark data", got, "1");

    done = 1;
    summary();
    $finish;
  end
endmodule